// File: doc/BRIEF.md
# Asynchronous Serial Communication Adapter

This block is a byte-wide, bus-attached serial adapter. A host reads and writes four registers through a small register port. The port has three chip selects, a register select, a read/write line, a one-cycle enable strobe and separate 8-bit input and output data buses. The four registers are a write-only control register, a read-only status register, a write-only transmit data register and a read-only receive data register. Serial timing comes from two external bit-rate clocks, one for transmit and one for receive. The block samples both clocks into its own system clock domain. Each serial clock can run at 1, 16 or 64 times the bit rate.

Words carry 7 or 8 data bits, least significant bit first. A word can have an optional even or odd parity bit and one or two stop bits. Three modem lines are handled in logic:
- a clear-to-send input, which gates the transmit-empty indication;
- a carrier-detect input, which holds the receiver idle and can latch a carrier-loss interrupt;
- a request-to-send output, decoded from two control bits.

The interrupt output is active low. It stays asserted while any enabled cause remains.

Status register layout: bit 0 receive full, bit 1 transmit empty, bit 2 carrier lost, bit 3 clear-to-send level, bit 4 framing error, bit 5 overrun, bit 6 parity error, bit 7 interrupt pending.

Top module: `uart_adp`

## Requirements
- R1: A register access happens only in a cycle with `en`=1, `cs0`=1, `cs1`=1 and `cs2_n`=0. The access type depends on `rs` and `rw`:
  - `rs`=0, `rw`=0: control write;
  - `rs`=1, `rw`=0: transmit data write;
  - `rs`=0, `rw`=1: status read;
  - `rs`=1, `rw`=1: receive data read.
  Read data appears on `dout` one clock later. A deselected access changes nothing.
- R2: Control bits 1:0 select the divide ratio: 00 gives ÷1, 01 gives ÷16, 10 gives ÷64. The transmitter advances on falling edges of `tx_clk`. The receiver samples on rising edges of `rx_clk`. In ÷16 and ÷64 the receiver confirms the start bit at the centre count and samples each later bit one bit time apart. In ÷1 it takes one bit per rising edge. A frame is a 0 start bit, the data bits LSB first, an optional parity bit, then stop bits at 1.
- R3: Control bits 4:2 select the word format:
  - 000: 7 data bits, even parity, 2 stop bits;
  - 001: 7 data bits, odd parity, 2 stop bits;
  - 010: 7 data bits, even parity, 1 stop bit;
  - 011: 7 data bits, odd parity, 1 stop bit;
  - 100: 8 data bits, no parity, 2 stop bits;
  - 101: 8 data bits, no parity, 1 stop bit;
  - 110: 8 data bits, even parity, 1 stop bit;
  - 111: 8 data bits, odd parity, 1 stop bit.
  With 7-bit words, the received bit 7 reads 0.
- R4: Status bit 1 is 1 only when the transmit data register is empty and `cts_n` is low. Status bit 3 shows the synchronised `cts_n` level.
- R5: `rts_n` is 0 when control bit 6 is 0, or when control bits 6:5 are 11. It is 1 when bits 6:5 are 10. It follows a control write on the next clock.
- R6: While `dcd_n` is high, the receiver is held idle and takes in no frame. Status bit 2 shows the `dcd_n` level, ORed with a carrier-lost flag. A rising edge on `dcd_n` sets that flag only when control bit 7 (receive interrupt enable) is 1.
- R7: `irq_n` is low while either of these holds:
  - control bit 7 is 1 and receive full, overrun or carrier-lost is set;
  - control bits 6:5 are 01 and status bit 1 is 1.
  Status bit 7 shows the same condition.
- R8: A receive data read clears receive full (status bit 0), overrun (bit 5) and the carrier-lost flag.
- R9: A frame that completes while receive full is set is dropped. It sets overrun (bit 5), and the earlier byte stays readable.
- R10: A received parity bit that does not match the format sets status bit 6. A first stop bit sampled as 0 sets status bit 4. Both flags update with each stored frame.
- R11: Control bits 1:0 = 11 form the master-reset state. In it:
  - both serial engines are held idle with `txd` high;
  - receive full, overrun, the error flags and carrier-lost are cleared;
  - transmit data writes are discarded.
- R12: After `rst`, the control register holds 0x03 (master reset). With `cts_n` and `dcd_n` low, status reads 0x02, `irq_n`=1, `rts_n`=0 and `txd`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs0 | input | 1 | Chip select, active high |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| rs | input | 1 | Register select: 1 data pair, 0 control/status pair |
| rw | input | 1 | 1 read, 0 write |
| en | input | 1 | Access strobe, one cycle per access |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| irq_n | output | 1 | Interrupt request, active low |
| tx_clk | input | 1 | Transmit bit-rate clock |
| rx_clk | input | 1 | Receive bit-rate clock |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| cts_n | input | 1 | Clear to send, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
The assertions assume the following about the inputs:
- each access strobe lasts one cycle;
- `tx_clk`, `rx_clk`, `rxd`, `cts_n` and `dcd_n` hold each level for at least three system clocks, so the synchronisers see every edge;
- the divide and format bits are rewritten only while both serial engines are idle.

The bench drives the serial clocks with an 8-cycle period and issues each access as a single-cycle strobe. Before every new control value it waits for a received byte to be flagged, or for a fixed idle time.

// File: rtl/uart_adp_pkg.sv
package uart_adp_pkg;

  typedef enum logic [1:0] {
    DIV_1    = 2'd0,
    DIV_16   = 2'd1,
    DIV_64   = 2'd2,
    DIV_MRST = 2'd3
  } div_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_st_e;

  typedef struct packed {
    logic eight;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } fmt_t;

  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    case (code)
      3'b000:  f = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b1};
      3'b001:  f = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b1};
      3'b010:  f = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
      3'b011:  f = '{eight: 1'b0, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
      3'b100:  f = '{eight: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b1};
      3'b101:  f = '{eight: 1'b1, par_en: 1'b0, par_odd: 1'b0, two_stop: 1'b0};
      3'b110:  f = '{eight: 1'b1, par_en: 1'b1, par_odd: 1'b0, two_stop: 1'b0};
      default: f = '{eight: 1'b1, par_en: 1'b1, par_odd: 1'b1, two_stop: 1'b0};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/uart_adp_sync.sv
module uart_adp_sync #(
  parameter int              W      = 1,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    RST    = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_adp_tx.sv
module uart_adp_tx
  import uart_adp_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tick,
  input  logic [CNT_W-1:0] last,
  input  fmt_t             fmt,
  input  logic [7:0]       data,
  input  logic             full,
  output logic             take,
  output logic             txd
);
  localparam int FR_W = 12;

  logic             busy;
  logic [FR_W-1:0]  sh, frame;
  logic [3:0]       left, nbits, len;
  logic [CNT_W-1:0] cnt;
  logic             par;

  assign nbits = fmt.eight ? 4'd8 : 4'd7;
  assign par   = (^(data & {fmt.eight, 7'h7f})) ^ fmt.par_odd;
  assign len   = 4'd2 + nbits + {3'b0, fmt.par_en} + {3'b0, fmt.two_stop};
  assign take  = tick & ~busy & full & ~hold;

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (4'(i) < nbits) frame[i+1] = data[i];
    if (fmt.par_en) frame[nbits+4'd1] = par;
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      cnt  <= '0;
      left <= '0;
      sh   <= '1;
    end else if (tick) begin
      if (!busy) begin
        if (full) begin
          sh   <= frame;
          txd  <= frame[0];
          left <= len - 4'd1;
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else if (cnt != last) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (left == 4'd0) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          sh   <= {1'b1, sh[FR_W-1:1]};
          txd  <= sh[1];
          left <= left - 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_adp_rx.sv
module uart_adp_rx
  import uart_adp_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tick,
  input  logic [CNT_W-1:0] last,
  input  logic [3:0]       nbits,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             rxd,
  output logic             done,
  output logic [7:0]       data,
  output logic             perr,
  output logic             ferr,
  output logic             busy
);
  rx_st_e           st;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       idx;

  assign busy = (st != RX_IDLE);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      idx  <= '0;
      data <= '0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else if (hold) begin
      st  <= RX_IDLE;
      cnt <= '0;
    end else if (tick) begin
      case (st)
        RX_IDLE: if (!rxd) begin
          cnt  <= '0;
          idx  <= '0;
          data <= '0;
          perr <= 1'b0;
          st   <= (last == '0) ? RX_BITS : RX_START;
        end
        RX_START: if (cnt == (last >> 1)) begin
          cnt <= '0;
          st  <= rxd ? RX_IDLE : RX_BITS;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: if (cnt != last) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          idx <= idx + 4'd1;
          if (idx < nbits) begin
            data[idx[2:0]] <= rxd;
          end else if (par_en && idx == nbits) begin
            perr <= (^data) ^ rxd ^ par_odd;
          end else begin
            ferr <= ~rxd;
            done <= 1'b1;
            st   <= RX_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/uart_adp.sv
module uart_adp
  import uart_adp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LO      = 16,
  parameter int DIV_HI      = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs0,
  input  logic       cs1,
  input  logic       cs2_n,
  input  logic       rs,
  input  logic       rw,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       irq_n,
  input  logic       tx_clk,
  input  logic       rx_clk,
  input  logic       rxd,
  output logic       txd,
  input  logic       cts_n,
  input  logic       dcd_n,
  output logic       rts_n
);
  localparam int          CNT_W    = $clog2(DIV_HI);
  localparam int          NSYNC    = 5;
  localparam logic [NSYNC-1:0] SYNC_RST = 5'b00001;
  localparam logic [7:0]  CTRL_RST = 8'h03;

  logic [7:0]       ctrl, ctrl_nx, tdr, rdr, status, rx_data;
  logic             tdr_full, rdrf, ovrn, pe_q, fe_q, dcd_lost;
  logic             sel, wr_ctl, wr_tdr, rd_st, rd_rdr;
  logic [NSYNC-1:0] s_now;
  logic             rxd_s, txc_s, rxc_s, cts_s, dcd_s;
  logic             txc_d, rxc_d, dcd_d;
  logic             tx_tick, rx_tick, dcd_rise;
  logic             mrst, tx_take, rx_done, rx_pe, rx_fe, rx_busy;
  logic             tdre, irq, rie, tie;
  logic [CNT_W-1:0] last;
  fmt_t             fmt;

  assign sel    = cs0 & cs1 & ~cs2_n;
  assign wr_ctl = en & sel & ~rw & ~rs;
  assign wr_tdr = en & sel & ~rw &  rs;
  assign rd_st  = en & sel &  rw & ~rs;
  assign rd_rdr = en & sel &  rw &  rs;

  uart_adp_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d({dcd_n, cts_n, rx_clk, tx_clk, rxd}),
    .q(s_now)
  );
  assign {dcd_s, cts_s, rxc_s, txc_s, rxd_s} = s_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      txc_d <= 1'b0;
      rxc_d <= 1'b0;
      dcd_d <= 1'b0;
    end else begin
      txc_d <= txc_s;
      rxc_d <= rxc_s;
      dcd_d <= dcd_s;
    end
  end

  assign tx_tick  = txc_d & ~txc_s;
  assign rx_tick  = ~rxc_d & rxc_s;
  assign dcd_rise = dcd_s & ~dcd_d;

  assign mrst = (ctrl[1:0] == DIV_MRST);
  assign fmt  = decode_fmt(ctrl[4:2]);
  assign rie  = ctrl[7];
  assign tie  = (ctrl[6:5] == 2'b01);

  always_comb begin
    case (ctrl[1:0])
      DIV_1:   last = '0;
      DIV_16:  last = CNT_W'(DIV_LO - 1);
      default: last = CNT_W'(DIV_HI - 1);
    endcase
  end

  uart_adp_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .hold(mrst), .tick(tx_tick), .last(last),
    .fmt(fmt), .data(tdr), .full(tdr_full), .take(tx_take), .txd(txd)
  );

  uart_adp_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .hold(mrst | dcd_s), .tick(rx_tick), .last(last),
    .nbits(fmt.eight ? 4'd8 : 4'd7), .par_en(fmt.par_en), .par_odd(fmt.par_odd),
    .rxd(rxd_s), .done(rx_done), .data(rx_data), .perr(rx_pe), .ferr(rx_fe),
    .busy(rx_busy)
  );

  assign tdre    = ~tdr_full & ~cts_s;
  assign irq     = (rie & (rdrf | ovrn | dcd_lost)) | (tie & tdre);
  assign status  = {irq, pe_q, ovrn, fe_q, cts_s, dcd_s | dcd_lost, tdre, rdrf};
  assign ctrl_nx = wr_ctl ? din : ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= CTRL_RST;
      tdr      <= '0;
      rdr      <= '0;
      tdr_full <= 1'b0;
      rdrf     <= 1'b0;
      ovrn     <= 1'b0;
      pe_q     <= 1'b0;
      fe_q     <= 1'b0;
      dcd_lost <= 1'b0;
      dout     <= '0;
      irq_n    <= 1'b1;
      rts_n    <= CTRL_RST[6] & ~CTRL_RST[5];
    end else begin
      ctrl <= ctrl_nx;
      if (tx_take) tdr_full <= 1'b0;
      if (wr_tdr) begin
        tdr      <= din;
        tdr_full <= 1'b1;
      end
      if (rd_rdr) begin
        rdrf     <= 1'b0;
        ovrn     <= 1'b0;
        dcd_lost <= 1'b0;
      end
      if (rx_done) begin
        if (rdrf && !rd_rdr) begin
          ovrn <= 1'b1;
        end else begin
          rdr  <= rx_data;
          rdrf <= 1'b1;
          pe_q <= rx_pe;
          fe_q <= rx_fe;
        end
      end
      if (dcd_rise && rie) dcd_lost <= 1'b1;
      if (mrst) begin
        tdr_full <= 1'b0;
        rdrf     <= 1'b0;
        ovrn     <= 1'b0;
        pe_q     <= 1'b0;
        fe_q     <= 1'b0;
        dcd_lost <= 1'b0;
      end
      if (rd_st)       dout <= status;
      else if (rd_rdr) dout <= rdr;
      irq_n <= ~irq;
      rts_n <= ctrl_nx[6] & ~ctrl_nx[5];
    end
  end
endmodule

// File: rtl/uart_adp_chk.sv
module uart_adp_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs0,
  input logic       cs1,
  input logic       cs2_n,
  input logic       rs,
  input logic       rw,
  input logic       en,
  input logic [1:0] din_rts,
  input logic       dout_tdre,
  input logic       rts_n,
  input logic       txd,
  input logic       mrst,
  input logic       rdrf,
  input logic       rx_done,
  input logic       rx_busy,
  input logic       cts_s,
  input logic       dcd_s
);
  logic sel;
  assign sel = cs0 & cs1 & ~cs2_n;

  // R5: request-to-send follows the control write one clock later
  assert_rts_decode_R5: assert property (@(posedge clk) disable iff (rst)
    (en && sel && !rw && !rs) |=> (rts_n == ($past(din_rts[1]) && !$past(din_rts[0]))));

  // R1: a deselected strobe leaves the modem output alone
  assert_deselect_R1: assert property (@(posedge clk) disable iff (rst)
    (en && !sel) |=> $stable(rts_n));

  // R4: clear-to-send high masks the transmit-empty bit on a status read
  assert_tdre_cts_R4: assert property (@(posedge clk) disable iff (rst)
    (en && sel && rw && !rs && cts_s) |=> !dout_tdre);

  // R8: a receive data read empties the buffer
  assert_read_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (en && sel && rw && rs && !rx_done) |=> !rdrf);

  // R6: carrier loss holds the receiver idle
  assert_dcd_hold_R6: assert property (@(posedge clk) disable iff (rst)
    dcd_s |=> !rx_busy);

  // R11: master reset keeps the line marking
  assert_mrst_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (mrst && $past(mrst)) |-> txd);
endmodule

bind uart_adp uart_adp_chk u_chk (
  .clk(clk), .rst(rst), .cs0(cs0), .cs1(cs1), .cs2_n(cs2_n), .rs(rs), .rw(rw),
  .en(en), .din_rts(din[6:5]), .dout_tdre(dout[1]), .rts_n(rts_n), .txd(txd),
  .mrst(mrst), .rdrf(rdrf), .rx_done(rx_done), .rx_busy(rx_busy),
  .cts_s(cts_s), .dcd_s(dcd_s)
);

// File: tb/sim_uart_adp.sv
`timescale 1ns/1ps
module sim_uart_adp;
  logic       clk = 1'b0, rst = 1'b1;
  logic       cs0 = 1'b0, cs1 = 1'b0, cs2_n = 1'b1, rs = 1'b0, rw = 1'b1, en = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       irq_n, txd, rts_n;
  logic       sclk = 1'b0, raw_rxd = 1'b1, loop = 1'b1;
  logic       cts_n = 1'b0, dcd_n = 1'b0;
  wire        rxd = loop ? txd : raw_rxd;
  int         total = 0, bad = 0;

  always #2.5 clk = ~clk;
  always #20  sclk = ~sclk;

  uart_adp u0 (
    .clk(clk), .rst(rst), .cs0(cs0), .cs1(cs1), .cs2_n(cs2_n), .rs(rs), .rw(rw),
    .en(en), .din(din), .dout(dout), .irq_n(irq_n), .tx_clk(sclk), .rx_clk(sclk),
    .rxd(rxd), .txd(txd), .cts_n(cts_n), .dcd_n(dcd_n), .rts_n(rts_n)
  );

  // {control, written byte, expected received byte}
  localparam logic [23:0] VEC [8] = '{
    {8'h15, 8'hA5, 8'hA5},   // 8N1 div16
    {8'h14, 8'h3C, 8'h3C},   // 8N1 div1
    {8'h01, 8'hD3, 8'h53},   // 7E2 div16
    {8'h0C, 8'h7F, 8'h7F},   // 7O1 div1
    {8'h19, 8'h81, 8'h81},   // 8E1 div16
    {8'h1E, 8'h00, 8'h00},   // 8O1 div64
    {8'h10, 8'hFF, 8'hFF},   // 8N2 div1
    {8'h09, 8'hC4, 8'h44}    // 7E1 div16
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [2:0] cs, input logic r_s, input logic r_w,
                     input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    {cs0, cs1, cs2_n} = cs;
    rs = r_s; rw = r_w; din = d; en = 1'b1;
    @(negedge clk);
    en = 1'b0; rw = 1'b1;
    q = dout;
  endtask

  task automatic wr(input logic r_s, input logic [7:0] d);
    logic [7:0] q;
    bus(3'b110, r_s, 1'b0, d, q);
  endtask

  task automatic rd(input logic r_s, output logic [7:0] q);
    bus(3'b110, r_s, 1'b1, 8'h00, q);
  endtask

  task automatic wait_full();
    logic [7:0] st;
    for (int k = 0; k < 3000; k++) begin
      rd(1'b0, st);
      if (st[0]) return;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic send_raw(input logic [11:0] f, input int n);
    @(negedge sclk);
    for (int i = 0; i < n; i++) begin
      raw_rxd = f[i];
      repeat (16) @(negedge sclk);
    end
    raw_rxd = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R12 rts_n", {7'b0, rts_n}, 8'h00);
    chk("R12 txd",   {7'b0, txd},   8'h01);
    rd(1'b0, q); chk("R12 status", q, 8'h02);

    // R2 R3 loopback walk over divides and formats
    for (int i = 0; i < 8; i++) begin
      wr(1'b0, VEC[i][23:16]);
      wr(1'b1, VEC[i][15:8]);
      wait_full();
      rd(1'b0, q); chk("R2/R3 status after frame", q, 8'h03);
      rd(1'b1, q); chk("R2/R3 received byte", q, VEC[i][7:0]);
      rd(1'b0, q); chk("R8 status after read", q, 8'h02);
    end

    // R5 request-to-send decode
    wr(1'b0, 8'h55); @(negedge clk); chk("R5 bits 10", {7'b0, rts_n}, 8'h01);
    wr(1'b0, 8'h75); @(negedge clk); chk("R5 bits 11", {7'b0, rts_n}, 8'h00);
    wr(1'b0, 8'h15); @(negedge clk); chk("R5 bits 00", {7'b0, rts_n}, 8'h00);

    // R1 deselected writes ignored
    bus(3'b111, 1'b0, 1'b0, 8'h55, q); @(negedge clk);
    chk("R1 cs2_n high ignored", {7'b0, rts_n}, 8'h00);
    bus(3'b010, 1'b0, 1'b0, 8'h55, q); @(negedge clk);
    chk("R1 cs0 low ignored", {7'b0, rts_n}, 8'h00);

    // R7 transmit-empty interrupt, R4 gating by clear-to-send
    wr(1'b0, 8'h35); repeat (3) @(negedge clk);
    chk("R7 tx empty irq", {7'b0, irq_n}, 8'h00);
    chk("R5 bits 01", {7'b0, rts_n}, 8'h00);
    cts_n = 1'b1; repeat (6) @(negedge clk);
    rd(1'b0, q); chk("R4 status with cts high", q, 8'h08);
    chk("R4 irq masked by cts", {7'b0, irq_n}, 8'h01);
    cts_n = 1'b0; repeat (6) @(negedge clk);
    rd(1'b0, q); chk("R4 status cts low", q, 8'h82);

    // R9 overrun
    wr(1'b0, 8'h14);
    wr(1'b1, 8'h11); wait_full();
    wr(1'b1, 8'h22); repeat (400) @(negedge clk);
    rd(1'b0, q); chk("R9 overrun status", q, 8'h23);
    rd(1'b1, q); chk("R9 first byte kept", q, 8'h11);
    rd(1'b0, q); chk("R8 overrun cleared", q, 8'h02);

    // R7 receive interrupt
    wr(1'b0, 8'h94); repeat (3) @(negedge clk);
    chk("R7 no cause", {7'b0, irq_n}, 8'h01);
    wr(1'b1, 8'h33); wait_full(); repeat (3) @(negedge clk);
    chk("R7 receive irq", {7'b0, irq_n}, 8'h00);
    rd(1'b1, q); chk("R7 byte", q, 8'h33);
    repeat (3) @(negedge clk);
    chk("R8 irq released", {7'b0, irq_n}, 8'h01);

    // R6 carrier loss with interrupt enabled
    dcd_n = 1'b1; repeat (6) @(negedge clk);
    chk("R6 loss irq", {7'b0, irq_n}, 8'h00);
    wr(1'b1, 8'h44); repeat (300) @(negedge clk);
    rd(1'b0, q); chk("R6 receiver held", q, 8'h86);
    dcd_n = 1'b0; repeat (6) @(negedge clk);
    rd(1'b0, q); chk("R6 loss latched", q, 8'h86);
    rd(1'b1, q); repeat (3) @(negedge clk);
    chk("R8 loss cleared irq", {7'b0, irq_n}, 8'h01);
    rd(1'b0, q); chk("R8 loss cleared status", q, 8'h02);

    // R6 carrier edge with interrupt disabled
    wr(1'b0, 8'h14);
    dcd_n = 1'b1; repeat (6) @(negedge clk);
    chk("R6 no irq when disabled", {7'b0, irq_n}, 8'h01);
    rd(1'b0, q); chk("R6 level shown", q, 8'h06);
    dcd_n = 1'b0; repeat (6) @(negedge clk);
    rd(1'b0, q); chk("R6 level gone", q, 8'h02);

    // R10 parity and framing with raw frames, 8E1 div16
    loop = 1'b0;
    wr(1'b0, 8'h19);
    send_raw({1'b0, 1'b1, 1'b0, 8'h5A, 1'b0}, 11); wait_full();
    rd(1'b0, q); chk("R10 good frame status", q, 8'h03);
    rd(1'b1, q); chk("R10 good frame byte", q, 8'h5A);
    send_raw({1'b0, 1'b1, 1'b1, 8'h5A, 1'b0}, 11); wait_full();
    rd(1'b0, q); chk("R10 parity error", q, 8'h43);
    rd(1'b1, q);
    send_raw({1'b0, 1'b0, 1'b0, 8'h5A, 1'b0}, 11); wait_full();
    rd(1'b0, q); chk("R10 framing error", q, 8'h13);
    rd(1'b1, q);

    // R11 master reset
    wr(1'b0, 8'h03); repeat (4) @(negedge clk);
    wr(1'b0, 8'h19);
    send_raw({1'b0, 1'b1, 1'b0, 8'h5A, 1'b0}, 11); wait_full();
    wr(1'b0, 8'h03); repeat (2) @(negedge clk);
    rd(1'b0, q); chk("R11 flags cleared", q, 8'h02);
    wr(1'b1, 8'h00); repeat (100) @(negedge clk);
    chk("R11 txd held high", {7'b0, txd}, 8'h01);
    rd(1'b0, q); chk("R11 tx write discarded", q, 8'h02);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule